// File: doc/BRIEF.md
# I2C Interrupt Vector and Status Unit

This unit collects the one-cycle event pulses of an I2C protocol engine into sticky status bits, qualifies them with a software-written enable mask, and offers a vector register. The vector returns a small numeric code for the most urgent enabled event that is pending. A read of the vector also acknowledges that event, so an interrupt handler can read the vector repeatedly until it returns zero. A single level interrupt line is high whenever any enabled event is pending.

Software reaches the unit over a 16-bit register bus with read and write strobes. Read data is combinational and valid in the same cycle as the read strobe. The bus-busy and receive-shift-full indications from the engine appear in the status word only. They never raise the interrupt and never appear in the vector.

A two-state machine drives the interrupt line. State QUIET (line low) moves to RAISED when the next cycle will hold an enabled pending event (transition ARM). RAISED returns to QUIET when the next cycle will hold none (transition DRAIN). Otherwise each state holds.

Top module: `i2c_event_vector`

## Requirements
- R1: After reset, all pending event bits and all mask bits are 0, the vector reads 0 and `irq` is low.
- R2: A pulse on `evt_pulse[i]` sets the matching status bit on the next clock, whether or not it is enabled. Event index and code: 0 arbitration lost (code 1), 1 NACK (2), 2 access ready (3), 3 receive ready (4), 4 transmit ready (5), 5 stop detected (6), 6 addressed as slave (7).
- R3: The status word at offset 0x08 shows events 0..5 at bits 0..5 and event 6 at bit 8. Writing 1 to one of these bits clears it, and writing 0 leaves it unchanged.
- R4: The mask at offset 0x04 holds bits 6:0 in event-index order and reads back with bits 15:7 as 0.
- R5: A read at offset 0x28 returns the code of the lowest-indexed pending event whose mask bit is 1, or 0 when there is none.
- R6: Status bit 11 follows `rx_shift_full` and bit 12 follows `bus_busy`. Writes do not change them, and they affect neither the vector nor `irq`.
- R7: A vector read that returns a nonzero code clears only that event's pending bit, taking effect at the clock edge ending the read.
- R8: An event pulse in the same cycle as a clear (vector read or status write) of its own bit leaves the bit set.
- R9: `irq` is high exactly when some pending bit and its mask bit are both 1.
- R10: A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (8) | Byte offset of the register |
| wdata | input | DATA_W (16) | Write data |
| rdata | output | DATA_W (16) | Read data, valid while `rd_en` is high |
| evt_pulse | input | 7 | One-cycle event pulses, indexed as in R2 |
| bus_busy | input | 1 | Bus busy level from the engine |
| rx_shift_full | input | 1 | Receive shift full level from the engine |
| irq | output | 1 | Level interrupt |

## Verification
The assertions take two things for granted. The address is stable while a strobe is high. The reset is applied before the first clock edge. The acknowledge assertion also relies on `rdata` being the vector code during a vector read.

The stimulus drives every input on the falling edge and holds it for a whole cycle. It asserts at most one strobe at a time, except where a pulse is deliberately aligned with a clearing access. It sweeps all 128 mask values against all 128 event patterns, so every priority ordering is reached.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
    localparam int NUM_EVT   = 7;
    localparam int CODE_W    = $clog2(NUM_EVT + 1);
    localparam int OFS_MASK  = 'h04;
    localparam int OFS_STAT  = 'h08;
    localparam int OFS_VEC   = 'h28;
    localparam int RXFULL_BIT = 11;
    localparam int BUSY_BIT   = 12;

    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } irq_state_e;

    // status-word position of event index idx
    function automatic int stat_pos(input int idx);
        return (idx == NUM_EVT - 1) ? 8 : idx;
    endfunction
endpackage

// File: rtl/i2c_evt_pending.sv
module i2c_evt_pending #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] nxt_o
);
    logic [N-1:0] pend_q;

    // a pulse wins over a same-cycle clear
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign nxt_o[g] = set_i[g] | (pend_q[g] & ~clr_i[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= nxt_o;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/i2c_evt_prio.sv
module i2c_evt_prio #(
    parameter int N      = 7,
    parameter int CODE_W = 3
) (
    input  logic [N-1:0]      req_i,
    output logic [CODE_W-1:0] code_o,
    output logic [N-1:0]      onehot_o
);
    // lowest index wins: scan downward, last hit stays
    always_comb begin
        code_o   = '0;
        onehot_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                code_o      = CODE_W'(i + 1);
                onehot_o    = '0;
                onehot_o[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_event_vector.sv
module i2c_event_vector
    import i2c_evt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    input  logic [NUM_EVT-1:0]   evt_pulse,
    input  logic                 bus_busy,
    input  logic                 rx_shift_full,
    output logic                 irq
);
    logic sel_mask, sel_stat, sel_vec;
    logic rd_vec, wr_stat, wr_mask;
    logic [NUM_EVT-1:0] mask_q, mask_d;
    logic [NUM_EVT-1:0] pend_q, pend_d;
    logic [NUM_EVT-1:0] w1c, clr, top_oh;
    logic [CODE_W-1:0]  top_code;
    logic [DATA_W-1:0]  stat_word;
    irq_state_e         state_q, state_d;
    logic               unused_wdata;

    assign sel_mask = (addr == ADDR_W'(OFS_MASK));
    assign sel_stat = (addr == ADDR_W'(OFS_STAT));
    assign sel_vec  = (addr == ADDR_W'(OFS_VEC));
    assign rd_vec   = rd_en & sel_vec;
    assign wr_stat  = wr_en & sel_stat;
    assign wr_mask  = wr_en & sel_mask;
    assign unused_wdata = ^wdata;

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_w1c
        assign w1c[g] = wr_stat & wdata[stat_pos(g)];
    end

    assign clr = w1c | (rd_vec ? top_oh : '0);

    i2c_evt_pending #(.N(NUM_EVT)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_pulse),
        .clr_i  (clr),
        .pend_o (pend_q),
        .nxt_o  (pend_d)
    );

    i2c_evt_prio #(.N(NUM_EVT), .CODE_W(CODE_W)) u_prio (
        .req_i    (pend_q & mask_q),
        .code_o   (top_code),
        .onehot_o (top_oh)
    );

    assign mask_d = wr_mask ? wdata[NUM_EVT-1:0] : mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    // next state: ARM and DRAIN transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (|(pend_d & mask_d))  state_d = ST_RAISED;
            ST_RAISED: if (!(|(pend_d & mask_d))) state_d = ST_QUIET;
            default:   state_d = ST_QUIET;
        endcase
    end

    // outputs
    always_comb begin
        irq = (state_q == ST_RAISED);
    end

    always_comb begin
        stat_word = '0;
        for (int i = 0; i < NUM_EVT; i++) stat_word[stat_pos(i)] = pend_q[i];
        stat_word[RXFULL_BIT] = rx_shift_full;
        stat_word[BUSY_BIT]   = bus_busy;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (sel_mask)      rdata = DATA_W'(mask_q);
            else if (sel_stat) rdata = stat_word;
            else if (sel_vec)  rdata = DATA_W'(top_code);
        end
    end
endmodule

// File: rtl/i2c_event_vector_chk.sv
module i2c_event_vector_chk
    import i2c_evt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_en,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  wdata,
    input logic [DATA_W-1:0]  rdata,
    input logic [NUM_EVT-1:0] evt_pulse,
    input logic               irq,
    input logic [NUM_EVT-1:0] pend,
    input logic [NUM_EVT-1:0] mask
);
    logic               rd_vec, wr_stat;
    logic [CODE_W-1:0]  vcode;
    logic [NUM_EVT-1:0] vec_oh, hit_oh_q, w1c_req;

    assign rd_vec  = rd_en && (addr == ADDR_W'(OFS_VEC));
    assign wr_stat = wr_en && (addr == ADDR_W'(OFS_STAT));
    assign vcode   = rdata[CODE_W-1:0];
    assign vec_oh  = (rd_vec && vcode != '0)
                   ? (NUM_EVT'(1) << (vcode - 1'b1)) : '0;

    always_comb begin
        for (int i = 0; i < NUM_EVT; i++)
            w1c_req[i] = wr_stat && wdata[stat_pos(i)] && !evt_pulse[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_oh_q <= '0;
        else        hit_oh_q <= vec_oh & ~evt_pulse;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pend == '0 && mask == '0 && !irq));

    // R2
    evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_pulse) |=> ((pend & $past(evt_pulse)) == $past(evt_pulse)));

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((pend & $past(w1c_req)) == '0));

    // R5
    vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vec && !irq) |-> (rdata == '0));

    // R7
    vec_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_oh_q != '0) |-> ((pend & hit_oh_q) == '0));

    // R9
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(pend & mask)));
endmodule

bind i2c_event_vector i2c_event_vector_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .evt_pulse (evt_pulse),
    .irq       (irq),
    .pend      (pend_q),
    .mask      (mask_q)
);

// File: tb/sim_i2c_event_vector.sv
module sim_i2c_event_vector;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [6:0]  evt_pulse = '0;
    logic        bus_busy = 1'b0, rx_shift_full = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_event_vector u0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .evt_pulse(evt_pulse), .bus_busy(bus_busy),
        .rx_shift_full(rx_shift_full), .irq(irq)
    );

    function automatic logic [15:0] stat_map(input logic [6:0] p);
        return {7'b0, p[6], 2'b0, p[5:0]};
    endfunction

    function automatic logic [15:0] low_code(input logic [6:0] p);
        for (int i = 0; i < 7; i++) if (p[i]) return 16'(i + 1);
        return 16'd0;
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [6:0] p);
        evt_pulse = p;
        @(posedge clk); @(negedge clk);
        evt_pulse = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [6:0]  en;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h04, d); chk("R1 mask", d, 16'h0);
        rd(8'h08, d); chk("R1 status", d, 16'h0);
        rd(8'h28, d); chk("R1 vector", d, 16'h0);
        chk("R1 irq", {15'b0, irq}, 16'h0);

        // R4 mask readback
        wr(8'h04, 16'hFFFF); rd(8'h04, d); chk("R4 mask all", d, 16'h007F);
        wr(8'h04, 16'h0055); rd(8'h04, d); chk("R4 mask pattern", d, 16'h0055);

        // R2 masked-off event still latches; R9 irq follows mask
        wr(8'h04, 16'h0000);
        pulse(7'b0000010);
        rd(8'h08, d); chk("R2 masked latch", d, 16'h0002);
        chk("R9 irq masked", {15'b0, irq}, 16'h0);
        rd(8'h28, d); chk("R5 vector masked", d, 16'h0);
        wr(8'h04, 16'h0002);
        chk("R9 irq enabled", {15'b0, irq}, 16'h1);
        wr(8'h08, 16'hFFFF);
        chk("R9 irq cleared", {15'b0, irq}, 16'h0);

        // R3 and R6 status layout, w1c, inputs
        bus_busy = 1'b1; rx_shift_full = 1'b1;
        wr(8'h04, 16'h007F);
        pulse(7'h7F);
        rd(8'h08, d); chk("R3 status all", d, 16'h193F);
        wr(8'h08, 16'h0005); rd(8'h08, d); chk("R3 w1c partial", d, 16'h193A);
        wr(8'h08, 16'h0000); rd(8'h08, d); chk("R3 write zero", d, 16'h193A);
        wr(8'h08, 16'hFFFF); rd(8'h08, d); chk("R6 level bits kept", d, 16'h1800);
        rd(8'h28, d); chk("R6 vector ignores levels", d, 16'h0);
        chk("R6 irq ignores levels", {15'b0, irq}, 16'h0);
        bus_busy = 1'b0; rx_shift_full = 1'b0;

        // R7 drain in priority order
        pulse(7'h7F);
        for (int k = 1; k <= 7; k++) begin
            rd(8'h28, d); chk("R7 drain code", d, 16'(k));
        end
        rd(8'h28, d); chk("R7 drained", d, 16'h0);

        // R8 same-cycle pulse and vector read
        pulse(7'b0000001);
        evt_pulse = 7'b0000001;
        rd(8'h28, d);
        evt_pulse = '0;
        chk("R8 read code", d, 16'h1);
        rd(8'h08, d); chk("R8 kept after read", d, 16'h0001);
        evt_pulse = 7'b0000001;
        wr(8'h08, 16'h0001);
        evt_pulse = '0;
        rd(8'h08, d); chk("R8 kept after w1c", d, 16'h0001);
        wr(8'h08, 16'hFFFF);

        // R10 unmapped offset
        pulse(7'h7F);
        rd(8'h10, d); chk("R10 unmapped", d, 16'h0);
        wr(8'h08, 16'hFFFF);

        // R5 R7 R9 R2 sweep of all masks against all patterns
        for (int m = 0; m < 128; m++) begin
            wr(8'h04, 16'(m));
            for (int p = 0; p < 128; p++) begin
                pulse(7'(p));
                en = 7'(p) & 7'(m);
                chk("R9 sweep irq", {15'b0, irq}, {15'b0, |en});
                rd(8'h28, d); chk("R5 sweep vector", d, low_code(en));
                rd(8'h08, d);
                if (en != 0)
                    chk("R7 sweep ack", d, stat_map(7'(p) & ~(7'd1 << (low_code(en) - 1))));
                else
                    chk("R2 sweep status", d, stat_map(7'(p)));
                wr(8'h08, 16'hFFFF);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule